// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Dispatcher Front End

This block sits between a host bus and the data movers of a scatter-gather DMA engine. Software fills an eight-word staging window with one extended transfer descriptor. The descriptor enters a FIFO as a single entry only when the last word, the control word, is written with its go bit set. The FIFO presents descriptors one at a time, each as a 256-bit flat word, to the read and write masters. A valid/ready handshake takes each one.

A second register window holds the control and status registers. It has sticky status flags that are cleared by writing one, a reset request that clears itself, policies that stop dispatch when an error or an early termination occurs, FIFO fill levels, and the sequence number of the descriptor most recently handed out. The data movers report completion through a one-cycle event. The event carries an error code and an early-termination flag, and it always refers to the descriptor most recently handed out. Together with the interrupt bits of that descriptor's control word, the event drives an interrupt line.

Top module: `sgdma_dispatch_fe`

## Requirements
- R1: Writes to staging words 0 to 6 (index = byte offset / 4) never add a FIFO entry. A write to word 7 with bit 31 clear adds no entry either.
- R2: A write to word 7 with bit 31 set pushes one entry. In that entry, bits [32i+31:32i] hold staging word i for i = 0 to 6, and bits [255:224] hold the written control value. Entries leave the FIFO in the order they were committed.
- R3: Status (CSR index 0) bit 1 reads 1 when the FIFO is empty and bit 2 reads 1 when it is full. CSR index 2 reports the FIFO occupancy in both bits 31:16 and bits 15:0.
- R4: A go write while the FIFO is full is dropped and the occupancy stays the same. It sets sticky status bit 10, which is cleared by writing 1 to it.
- R5: fifo_out_valid is high only when the FIFO is not empty and dispatch is enabled. Control (CSR index 1) bit 0 (stop) and bit 5 (stop fetching) each hold it low. Status bit 5 reads 1 while stop is set or while either stop flag from R8 or R9 is set.
- R6: Writing control bit 1 sets status bit 6 for exactly RST_CYCLES cycles, and the bit then clears itself. During that time the FIFO is flushed, the staging words are zeroed, the sticky flags are cleared, and staging writes are ignored. Control bit 1 reads back as status bit 6.
- R7: A completion event with no error and no early flag sets pending (status bit 9) when bit 14 of the in-flight control word is set. irq is the pending bit ANDed with control bit 4. Writing 1 to status bit 9 clears pending.
- R8: A completion event whose error code ANDed with bits 23:16 of the in-flight control word is nonzero sets pending. With control bit 2 set, any nonzero error code sets status bit 7 and halts dispatch until status bit 7 is cleared by writing 1 to it.
- R9: A completion event with the early flag set sets pending when bit 15 of the in-flight control word is set. With control bit 3 set, it also sets status bit 8 and halts dispatch.
- R10: Status bit 0 (busy) reads 1 when mover_busy is high or the FIFO holds an entry. Bit 3 always reads 1 and bit 4 always reads 0.
- R11: CSR index 4 holds bits 15:0 of staging word 3 from the most recently dispatched descriptor, in both bits 31:16 and bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsc_wr_en | input | 1 | Staging window write strobe |
| dsc_wr_idx | input | 3 | Staging word index |
| dsc_wr_data | input | 32 | Staging write data |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_idx | input | 3 | CSR word index for read and write |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational from csr_idx |
| fifo_out_valid | output | 1 | A descriptor is offered to the movers |
| fifo_out_ready | input | 1 | Movers accept the offered descriptor |
| fifo_out_data | output | 256 | Offered descriptor, word i in bits [32i+31:32i] |
| mover_busy | input | 1 | Data movers are working |
| done_valid | input | 1 | Completion event for the in-flight descriptor |
| done_err | input | 8 | Error code carried by the completion event |
| done_early | input | 1 | Completion was an early termination |
| irq | output | 1 | Interrupt request |

## Verification
All register effects show up one clock edge after their stimulus. A commit, pop, W1C or completion event captured on edge N is visible on csr_rdata, fifo_out_valid and irq before edge N+1, because reads are combinational. The bench drives stimulus on the falling edge and samples on the falling edge that follows the capturing rising edge. The reset flag is the one multi-cycle result. The bench checks that it is still high after the capturing edge plus RST_CYCLES-1 further edges and that it is low one edge later.

// File: rtl/sgdma_fe_pkg.sv
package sgdma_fe_pkg;
   localparam int WORD_W     = 32;
   localparam int N_WORDS    = 8;
   localparam int CTL_WORD   = 7;
   localparam int SEQ_WORD   = 3;
   localparam int GO_BIT     = 31;

   // control word bits of a descriptor
   localparam int DC_COMP_IE  = 14;
   localparam int DC_EARLY_IE = 15;
   localparam int DC_EMASK_LO = 16;

   // CSR indices
   localparam logic [2:0] CSR_STATUS = 3'd0;
   localparam logic [2:0] CSR_CTRL   = 3'd1;
   localparam logic [2:0] CSR_LEVEL  = 3'd2;
   localparam logic [2:0] CSR_RESP   = 3'd3;
   localparam logic [2:0] CSR_SEQ    = 3'd4;

   // status bit positions
   localparam int ST_BUSY   = 0;
   localparam int ST_EMPTY  = 1;
   localparam int ST_FULL   = 2;
   localparam int ST_REMPTY = 3;
   localparam int ST_RFULL  = 4;
   localparam int ST_STOP   = 5;
   localparam int ST_RST    = 6;
   localparam int ST_ERR    = 7;
   localparam int ST_EARLY  = 8;
   localparam int ST_PEND   = 9;
   localparam int ST_OVF    = 10;

   // control bit positions
   localparam int CT_STOP   = 0;
   localparam int CT_RESET  = 1;
   localparam int CT_SOERR  = 2;
   localparam int CT_SOEARLY= 3;
   localparam int CT_GIE    = 4;
   localparam int CT_NOFETCH= 5;

   typedef struct packed {
      logic [7:0] emask;
      logic       early_ie;
      logic       comp_ie;
   } inflight_t;
endpackage

// File: rtl/sgdma_fe_stage.sv
module sgdma_fe_stage #(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 8,
   parameter int GO_BIT  = 31,
   localparam int IDX_W  = $clog2(N_WORDS),
   localparam int STG_W  = WORD_W * (N_WORDS - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic              commit,
   output logic [WORD_W*N_WORDS-1:0] entry
);
   if (N_WORDS < 2) begin : g_bad_words
      $fatal(1, "sgdma_fe_stage: N_WORDS must be at least 2");
   end
   if (GO_BIT >= WORD_W) begin : g_bad_go
      $fatal(1, "sgdma_fe_stage: GO_BIT outside the word");
   end

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

   logic [STG_W-1:0] stage_flat;

   for (genvar i = 0; i < N_WORDS - 1; i++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (clear)
            word_q <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))
            word_q <= wr_data;
      end
      assign stage_flat[WORD_W*i +: WORD_W] = word_q;
   end

   assign commit = wr_en && !clear && (wr_idx == LAST_IDX) && wr_data[GO_BIT];
   assign entry  = {wr_data, stage_flat};
endmodule

// File: rtl/sgdma_fe_fifo.sv
module sgdma_fe_fifo #(
   parameter int W     = 256,
   parameter int DEPTH = 4,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic          empty,
   output logic          full,
   output logic [LW-1:0] level,
   output logic          ovf_evt
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $fatal(1, "sgdma_fe_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == LW'(DEPTH));
   assign do_push = push && !full && !clear;
   assign do_pop  = pop && !empty && !clear;
   assign ovf_evt = push && full && !clear;
   assign level   = cnt;
   assign head    = mem[rd_ptr];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[s] <= '0;
         else if (do_push && wr_ptr == AW'(s))
            mem[s] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + LW'(do_push) - LW'(do_pop);
      end
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LW'(DEPTH)) else $error("level above depth"); // R3
   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clear) |=> full) else $error("full lost on drop"); // R4
endmodule

// File: rtl/sgdma_fe_csr.sv
module sgdma_fe_csr
   import sgdma_fe_pkg::*;
#(
   parameter int RST_CYCLES = 4,
   parameter int LVL_W      = 3,
   localparam int RC_W      = $clog2(RST_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr_en,
   input  logic [2:0]        csr_idx,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic              ovf_evt,
   input  logic              pop,
   input  inflight_t         pop_ctl,
   input  logic [15:0]       pop_seq,
   input  logic              mover_busy,
   input  logic              done_valid,
   input  logic [7:0]        done_err,
   input  logic              done_early,
   output logic              resetting,
   output logic              dispatch_en,
   output logic              irq
);
   if (RST_CYCLES < 1) begin : g_bad_rst
      $fatal(1, "sgdma_fe_csr: RST_CYCLES must be at least 1");
   end
   if (LVL_W >= 16) begin : g_bad_lvl
      $fatal(1, "sgdma_fe_csr: level does not fit a 16-bit field");
   end

   logic [5:0]      ctl_q;
   logic [RC_W-1:0] rc_q;
   logic            pend_q, serr_q, searly_q, ovf_q;
   inflight_t       infl_q;
   logic [15:0]     seq_q;

   logic wr_ctl, wr_st, start_rst;
   logic comp_hit, err_hit, early_hit, any_err;
   logic pend_set, serr_set, searly_set;
   logic [15:0] lvl16;
   logic unused_wdata;

   assign wr_ctl    = csr_wr_en && csr_idx == CSR_CTRL && !resetting;
   assign wr_st     = csr_wr_en && csr_idx == CSR_STATUS;
   assign start_rst = wr_ctl && csr_wdata[CT_RESET];
   assign unused_wdata = ^csr_wdata[31:11];

   assign any_err    = (done_err != 8'd0);
   assign comp_hit   = done_valid && !any_err && !done_early && infl_q.comp_ie;
   assign err_hit    = done_valid && ((done_err & infl_q.emask) != 8'd0);
   assign early_hit  = done_valid && done_early && infl_q.early_ie;
   assign pend_set   = comp_hit || err_hit || early_hit;
   assign serr_set   = done_valid && any_err && ctl_q[CT_SOERR];
   assign searly_set = done_valid && done_early && ctl_q[CT_SOEARLY];

   // control register and self-clearing reset sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q     <= '0;
         resetting <= 1'b0;
         rc_q      <= '0;
      end else begin
         if (wr_ctl)
            ctl_q <= csr_wdata[5:0] & ~(6'd1 << CT_RESET);
         if (start_rst) begin
            resetting <= 1'b1;
            rc_q      <= RC_W'(RST_CYCLES);
         end else if (resetting) begin
            rc_q <= rc_q - 1'b1;
            if (rc_q == RC_W'(1))
               resetting <= 1'b0;
         end
      end
   end

   // sticky flags: set wins over write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         serr_q   <= 1'b0;
         searly_q <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (resetting) begin
         pend_q   <= 1'b0;
         serr_q   <= 1'b0;
         searly_q <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         pend_q   <= (pend_q   && !(wr_st && csr_wdata[ST_PEND]))  || pend_set;
         serr_q   <= (serr_q   && !(wr_st && csr_wdata[ST_ERR]))   || serr_set;
         searly_q <= (searly_q && !(wr_st && csr_wdata[ST_EARLY])) || searly_set;
         ovf_q    <= (ovf_q    && !(wr_st && csr_wdata[ST_OVF]))   || ovf_evt;
      end
   end

   // record of the descriptor most recently handed to the movers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         infl_q <= '0;
         seq_q  <= '0;
      end else if (resetting) begin
         infl_q <= '0;
         seq_q  <= '0;
      end else if (pop) begin
         infl_q <= pop_ctl;
         seq_q  <= pop_seq;
      end
   end

   assign dispatch_en = !resetting && !ctl_q[CT_STOP] && !ctl_q[CT_NOFETCH]
                        && !serr_q && !searly_q;
   assign irq   = pend_q && ctl_q[CT_GIE];
   assign lvl16 = {{(16-LVL_W){1'b0}}, fifo_level};

   always_comb begin
      csr_rdata = '0;
      case (csr_idx)
         CSR_STATUS: begin
            csr_rdata[ST_BUSY]   = mover_busy || !fifo_empty;
            csr_rdata[ST_EMPTY]  = fifo_empty;
            csr_rdata[ST_FULL]   = fifo_full;
            csr_rdata[ST_REMPTY] = 1'b1;
            csr_rdata[ST_RFULL]  = 1'b0;
            csr_rdata[ST_STOP]   = ctl_q[CT_STOP] || serr_q || searly_q;
            csr_rdata[ST_RST]    = resetting;
            csr_rdata[ST_ERR]    = serr_q;
            csr_rdata[ST_EARLY]  = searly_q;
            csr_rdata[ST_PEND]   = pend_q;
            csr_rdata[ST_OVF]    = ovf_q;
         end
         CSR_CTRL: begin
            csr_rdata[5:0]      = ctl_q;
            csr_rdata[CT_RESET] = resetting;
         end
         CSR_LEVEL: csr_rdata = {lvl16, lvl16};
         CSR_RESP:  csr_rdata = '0;
         CSR_SEQ:   csr_rdata = {seq_q, seq_q};
         default:   csr_rdata = '0;
      endcase
   end

   AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(done_valid)) else $error("pending without event"); // R7
   AST_ERR_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(serr_q) |-> $past(done_valid && done_err != 8'd0)) else $error("error stop without error"); // R8
   AST_EARLY_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(searly_q) |-> $past(done_valid && done_early)) else $error("early stop without early"); // R9
   AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (resetting && rc_q == RC_W'(1) && !start_rst) |=> !resetting) else $error("reset flag stuck"); // R6
endmodule

// File: rtl/sgdma_dispatch_fe.sv
module sgdma_dispatch_fe
   import sgdma_fe_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int RST_CYCLES = 4,
   localparam int ENT_W     = WORD_W * N_WORDS,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dsc_wr_en,
   input  logic [2:0]       dsc_wr_idx,
   input  logic [31:0]      dsc_wr_data,
   input  logic             csr_wr_en,
   input  logic [2:0]       csr_idx,
   input  logic [31:0]      csr_wdata,
   output logic [31:0]      csr_rdata,
   output logic             fifo_out_valid,
   input  logic             fifo_out_ready,
   output logic [255:0]     fifo_out_data,
   input  logic             mover_busy,
   input  logic             done_valid,
   input  logic [7:0]       done_err,
   input  logic             done_early,
   output logic             irq
);
   logic             resetting, dispatch_en, commit, ovf_evt, pop;
   logic             f_empty, f_full;
   logic [LVL_W-1:0] f_level;
   logic [ENT_W-1:0] entry, head;
   logic [31:0]      head_ctl;
   inflight_t        pop_ctl;

   sgdma_fe_stage #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .GO_BIT(GO_BIT)) u_stage (
      .clk(clk), .rst_n(rst_n), .clear(resetting),
      .wr_en(dsc_wr_en), .wr_idx(dsc_wr_idx), .wr_data(dsc_wr_data),
      .commit(commit), .entry(entry)
   );

   sgdma_fe_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clear(resetting),
      .push(commit), .push_data(entry), .pop(pop),
      .head(head), .empty(f_empty), .full(f_full),
      .level(f_level), .ovf_evt(ovf_evt)
   );

   assign head_ctl       = head[WORD_W*CTL_WORD +: WORD_W];
   assign pop_ctl.emask    = head_ctl[DC_EMASK_LO +: 8];
   assign pop_ctl.early_ie = head_ctl[DC_EARLY_IE];
   assign pop_ctl.comp_ie  = head_ctl[DC_COMP_IE];
   assign fifo_out_valid = !f_empty && dispatch_en;
   assign fifo_out_data  = head;
   assign pop            = fifo_out_valid && fifo_out_ready;

   sgdma_fe_csr #(.RST_CYCLES(RST_CYCLES), .LVL_W(LVL_W)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .csr_wr_en(csr_wr_en), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata),
      .fifo_empty(f_empty), .fifo_full(f_full), .fifo_level(f_level),
      .ovf_evt(ovf_evt), .pop(pop), .pop_ctl(pop_ctl),
      .pop_seq(head[WORD_W*SEQ_WORD +: 16]),
      .mover_busy(mover_busy), .done_valid(done_valid),
      .done_err(done_err), .done_early(done_early),
      .resetting(resetting), .dispatch_en(dispatch_en), .irq(irq)
   );

   logic unused_head;
   assign unused_head = ^{head_ctl[31:24], head_ctl[13:0]};

   AST_COMMIT_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (f_level > $past(f_level)) |-> $past(dsc_wr_en && dsc_wr_idx == 3'd7 && dsc_wr_data[31]))
      else $error("entry added without go"); // R2
   AST_NO_DISPATCH_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      resetting |-> !fifo_out_valid) else $error("dispatch during reset"); // R6
   AST_FLUSHED_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(resetting) |-> f_empty) else $error("fifo not flushed"); // R6
   AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_out_valid && !fifo_out_ready && !resetting) |=> $stable(fifo_out_data))
      else $error("offered descriptor changed"); // R2
endmodule

// File: tb/sgdma_dispatch_fe_tb.sv
module sgdma_dispatch_fe_tb;
   localparam int DEPTH = 4;
   localparam int RSTC  = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         dsc_wr_en = 1'b0;
   logic [2:0]   dsc_wr_idx = '0;
   logic [31:0]  dsc_wr_data = '0;
   logic         csr_wr_en = 1'b0;
   logic [2:0]   csr_idx = '0;
   logic [31:0]  csr_wdata = '0;
   logic [31:0]  csr_rdata;
   logic         fifo_out_valid;
   logic         fifo_out_ready = 1'b0;
   logic [255:0] fifo_out_data;
   logic         mover_busy = 1'b0;
   logic         done_valid = 1'b0;
   logic [7:0]   done_err = '0;
   logic         done_early = 1'b0;
   logic         irq;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   sgdma_dispatch_fe #(.FIFO_DEPTH(DEPTH), .RST_CYCLES(RSTC)) u_dut (.*);

   // {idx, data, expected level}
   localparam logic [38:0] VEC [12] = '{
      {3'd0, 32'h1000_0000, 4'd0},
      {3'd1, 32'h2000_0000, 4'd0},
      {3'd2, 32'h0000_0040, 4'd0},
      {3'd3, 32'h0800_0007, 4'd0},
      {3'd4, 32'h0001_0001, 4'd0},
      {3'd5, 32'h0000_0000, 4'd0},
      {3'd6, 32'h0000_0000, 4'd0},
      {3'd7, 32'h0000_4000, 4'd0},
      {3'd7, 32'h8000_4000, 4'd1},
      {3'd3, 32'h0000_0009, 4'd1},
      {3'd7, 32'h80FF_0000, 4'd2},
      {3'd2, 32'h0000_0080, 4'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic dwr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      dsc_wr_en = 1'b1; dsc_wr_idx = idx; dsc_wr_data = d;
      @(negedge clk);
      dsc_wr_en = 1'b0;
   endtask

   task automatic cwr(input logic [2:0] idx, input logic [31:0] d);
      @(negedge clk);
      csr_wr_en = 1'b1; csr_idx = idx; csr_wdata = d;
      @(negedge clk);
      csr_wr_en = 1'b0;
   endtask

   task automatic crd(input logic [2:0] idx, output logic [31:0] v);
      csr_idx = idx;
      #1 v = csr_rdata;
   endtask

   task automatic take(output logic [255:0] d);
      @(negedge clk);
      fifo_out_ready = 1'b1;
      #1 d = fifo_out_data;
      @(negedge clk);
      fifo_out_ready = 1'b0;
   endtask

   task automatic done(input logic [7:0] e, input logic early);
      @(negedge clk);
      done_valid = 1'b1; done_err = e; done_early = early;
      @(negedge clk);
      done_valid = 1'b0; done_err = '0; done_early = 1'b0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      logic [31:0]  v;
      logic [255:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      crd(3'd0, v); chk("R10 R3 reset status", v, 32'h0000_000A);
      crd(3'd1, v); chk("R5 reset control", v, 32'h0);
      chk("R7 reset irq", {31'd0, irq}, 32'd0);
      chk("R5 reset valid", {31'd0, fifo_out_valid}, 32'd0);

      // table walk: staging writes and commits
      for (int i = 0; i < 12; i++) begin
         dwr(VEC[i][38:36], VEC[i][35:4]);
         crd(3'd2, v);
         chk((i == 8 || i == 10) ? "R2 commit level" : "R1 no commit level",
             v, {12'd0, VEC[i][3:0], 12'd0, VEC[i][3:0]});
      end
      crd(3'd0, v); chk("R3 nonempty status", v & 32'h7, 32'h1);

      // stop holds dispatch
      cwr(3'd1, 32'h0000_0001);
      chk("R5 stop holds valid", {31'd0, fifo_out_valid}, 32'd0);
      crd(3'd0, v); chk("R5 stopped bit", (v >> 5) & 32'h1, 32'h1);
      cwr(3'd1, 32'h0000_0020);
      chk("R5 nofetch holds valid", {31'd0, fifo_out_valid}, 32'd0);
      cwr(3'd1, 32'h0000_0010);
      chk("R5 valid when enabled", {31'd0, fifo_out_valid}, 32'd1);

      // first entry contents and order
      take(d);
      chk("R2 word0", d[31:0], 32'h1000_0000);
      chk("R2 word3", d[127:96], 32'h0800_0007);
      chk("R2 word7", d[255:224], 32'h8000_4000);
      crd(3'd4, v); chk("R11 seq after pop", v, 32'h0007_0007);
      crd(3'd2, v); chk("R3 level after pop", v, 32'h0001_0001);

      // completion interrupt
      done(8'h00, 1'b0);
      crd(3'd0, v); chk("R7 pending set", (v >> 9) & 32'h1, 32'h1);
      chk("R7 irq high", {31'd0, irq}, 32'd1);
      cwr(3'd0, 32'h0000_0200);
      chk("R7 irq cleared", {31'd0, irq}, 32'd0);

      // second entry: error mask FF, stop on error
      take(d);
      chk("R2 second word2", d[95:64], 32'h0000_0040);
      chk("R2 second word3", d[127:96], 32'h0000_0009);
      crd(3'd4, v); chk("R11 seq second", v, 32'h0009_0009);
      cwr(3'd1, 32'h0000_0014);
      done(8'h02, 1'b0);
      crd(3'd0, v); chk("R8 err flags", v & 32'h3A0, 32'h2A0);
      chk("R8 irq on error", {31'd0, irq}, 32'd1);
      dwr(3'd7, 32'h8000_8000);
      chk("R8 dispatch halted", {31'd0, fifo_out_valid}, 32'd0);
      cwr(3'd0, 32'h0000_0280);
      chk("R8 dispatch resumes", {31'd0, fifo_out_valid}, 32'd1);

      // early termination
      take(d);
      cwr(3'd1, 32'h0000_0018);
      done(8'h00, 1'b1);
      crd(3'd0, v); chk("R9 early flags", v & 32'h3A0, 32'h320);
      cwr(3'd0, 32'h0000_0300);
      crd(3'd0, v); chk("R9 early cleared", v & 32'h3A0, 32'h0);

      // overflow
      for (int k = 0; k < DEPTH; k++) dwr(3'd7, 32'h8000_0000);
      crd(3'd2, v); chk("R3 full level", v, 32'h0004_0004);
      crd(3'd0, v); chk("R3 full bit", (v >> 2) & 32'h1, 32'h1);
      dwr(3'd7, 32'h8000_0000);
      crd(3'd2, v); chk("R4 level kept", v, 32'h0004_0004);
      crd(3'd0, v); chk("R4 overflow set", (v >> 10) & 32'h1, 32'h1);
      cwr(3'd0, 32'h0000_0400);
      crd(3'd0, v); chk("R4 overflow cleared", (v >> 10) & 32'h1, 32'h0);

      // reset sequence
      dwr(3'd0, 32'hDEAD_BEEF);
      cwr(3'd1, 32'h0000_0012);
      crd(3'd0, v); chk("R6 resetting high", (v >> 6) & 32'h1, 32'h1);
      crd(3'd1, v); chk("R6 reset bit reads", v, 32'h0000_0012);
      repeat (RSTC - 1) @(negedge clk);
      crd(3'd0, v); chk("R6 still resetting", (v >> 6) & 32'h1, 32'h1);
      @(negedge clk);
      crd(3'd0, v); chk("R6 reset done status", v, 32'h0000_000A);
      crd(3'd1, v); chk("R6 reset bit cleared", v, 32'h0000_0010);

      // busy from mover
      mover_busy = 1'b1;
      crd(3'd0, v); chk("R10 busy from mover", v & 32'h1, 32'h1);
      mover_busy = 1'b0;

      // staging zeroed by reset
      dwr(3'd7, 32'h8000_0000);
      take(d);
      chk("R6 staging zeroed", d[31:0] | d[223:192], 32'h0);
      chk("R6 ctl word", d[255:224], 32'h8000_0000);

      finish_run();
   end
endmodule